// File: doc/BRIEF.md
# HDLC Receive Deframer with Byte Status Tags

This block takes a serial HDLC bit stream, qualified by a per-bit enable, and turns it into tagged bytes for a receive FIFO. It watches the raw line for opening and closing flags, aborts, a go-ahead and an idle channel. Inside a frame it removes the zero that the transmitter inserts after five ones, packs bits into bytes least significant bit first, and runs the reflected CRC-16 over every recovered bit, FCS included.

Bytes reach the FIFO write port through a three-byte delay line. The two FCS bytes are therefore never written, and a frame too short to carry a header leaves no trace. Each write has a two-bit position and status tag, so the reader can tell where a packet starts and whether it ended well. The FIFO storage, address matching and any register access are outside this block.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A flag is eight raw bits 0,1,1,1,1,1,1,0 in time order. It sets byte alignment, so the first bit after it is bit 0 of the first byte. Bits arrive LSB first. A flag both ends a frame and opens the next one.
- R2: Inside a frame, a 0 that follows five consecutive data ones is removed before byte assembly and CRC.
- R3: A frame with fewer than 25 data bits between flags, counted after zero removal, writes nothing.
- R4: A frame with 25 to 31 data bits writes exactly two entries. The first is the first byte, tagged first. The second is the second byte, tagged last-bad.
- R5: The CRC is the reflected CRC-16 with polynomial 0x8408 and preset 0xFFFF. The transmitter sends the complement of the register, low byte first. A frame is good when it has a whole number of bytes and the register equals 0xF0B8 at the closing flag. The last data byte is then tagged last-good, and the two FCS bytes are not written.
- R6: A frame of 32 or more bits with a wrong FCS ends with its last data byte tagged last-bad.
- R7: Seven consecutive raw ones inside a frame abort it. If 25 or more data bits had been recovered, the next unwritten byte is written tagged last-bad; otherwise nothing is written. Reception then waits for a new flag.
- R8: The tag encoding is 00 for a packet byte, 01 for the first byte, 10 for the last byte of a good packet and 11 for the last byte of a bad packet. Each packet writes one first, then zero or more packet bytes, then exactly one last.
- R9: idle_o is high from the cycle after the 15th consecutive raw one is taken until a 0 is taken.
- R10: After a 0, seven ones and a closing 0 are taken, go_ahead_o is high for exactly one cycle, the cycle after that last 0.
- R11: While rst_ni is low, wr_en_o, idle_o and go_ahead_o are low.
- R12: A bit is taken only in cycles where bit_en_i is high. Gaps between bits do not change the bytes or tags written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Take bit_i in this cycle |
| bit_i | input | 1 | Serial line bit |
| wr_en_o | output | 1 | FIFO write strobe, one cycle per byte |
| wr_data_o | output | 8 | Byte to write |
| wr_tag_o | output | 2 | Position and status tag of the byte |
| idle_o | output | 1 | Idle channel seen |
| go_ahead_o | output | 1 | One-cycle go-ahead pulse |

## Verification
The assertions assume that the bits of a frame arrive through bit_en_i. Mid-packet writes are taken to follow a taken bit by one cycle, and last writes to follow a closing flag or abort bit by two cycles. They also assume the line never has two go-ahead endings in consecutive cycles. The stimulus meets this by holding bit_en_i high for one cycle per bit, with runs of zero or two blank cycles between bits. Every frame boundary comes from a real flag or from a run of seven or more ones. Payloads are stuffed by the bench, so a flag can appear only where the bench sends one.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    TAG_MID     = 2'b00,
    TAG_FIRST   = 2'b01,
    TAG_END_OK  = 2'b10,
    TAG_END_BAD = 2'b11
  } tag_e;

  localparam logic [7:0] FLAG_PAT = 8'h7E;
endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_ONES  = 15,
  parameter int ABORT_ONES = 7,
  parameter int GA_ONES    = 7,
  parameter int STUFF_ONES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  output logic dvld_o,
  output logic dbit_o,
  output logic eof_o,
  output logic eof_abort_o,
  output logic idle_o,
  output logic go_ahead_o
);
  localparam int OW = $clog2(IDLE_ONES + 1);
  localparam int SW = $clog2(STUFF_ONES + 1);

  logic [7:0]    win_q, vld_q, win_d;
  logic [OW-1:0] ones_q;
  logic [SW-1:0] oones_q;
  logic          act_q, zseen_q, eof_q, abort_q, ga_q;
  logic          flag_det, abort_det, proc, stuffed;

  // raw window: oldest bit in win_q[0], leaves after eight more bits
  assign win_d     = {bit_i, win_q[7:1]};
  assign flag_det  = bit_en_i && (win_d == FLAG_PAT);
  assign abort_det = bit_en_i && bit_i && (ones_q == OW'(ABORT_ONES - 1));
  assign proc      = bit_en_i && vld_q[0] && act_q;
  assign stuffed   = !win_q[0] && (oones_q == SW'(STUFF_ONES));

  assign dvld_o      = proc && !stuffed;
  assign dbit_o      = win_q[0];
  assign eof_o       = eof_q;
  assign eof_abort_o = abort_q;
  assign idle_o      = (ones_q >= OW'(IDLE_ONES));
  assign go_ahead_o  = ga_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      vld_q   <= '0;
      ones_q  <= '0;
      oones_q <= '0;
      act_q   <= 1'b0;
      zseen_q <= 1'b0;
      eof_q   <= 1'b0;
      abort_q <= 1'b0;
      ga_q    <= 1'b0;
    end else begin
      eof_q   <= flag_det || (abort_det && act_q);
      abort_q <= abort_det;
      ga_q    <= bit_en_i && !bit_i && zseen_q && (ones_q == OW'(GA_ONES));
      if (bit_en_i) begin
        win_q   <= win_d;
        // flag or abort bits must never reach the data path
        vld_q   <= (flag_det || abort_det) ? '0 : {1'b1, vld_q[7:1]};
        zseen_q <= zseen_q || !bit_i;
        if (!bit_i)                         ones_q <= '0;
        else if (ones_q != OW'(IDLE_ONES))  ones_q <= ones_q + OW'(1);
      end
      if (flag_det)       act_q <= 1'b1;
      else if (abort_det) act_q <= 1'b0;
      if (flag_det)                                  oones_q <= '0;
      else if (proc && !win_q[0])                    oones_q <= '0;
      else if (proc && oones_q != SW'(STUFF_ONES))   oones_q <= oones_q + SW'(1);
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter int           W       = 16,
  parameter logic [W-1:0] POLY    = 16'h8408,
  parameter logic [W-1:0] INIT    = 16'hFFFF,
  parameter logic [W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic ok_o
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb    = crc_q[0] ^ bit_i;
  assign crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
  assign ok_o  = (crc_q == RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (en_i)  crc_q <= crc_d;
  end
endmodule

// File: rtl/hdlc_rx_pack.sv
module hdlc_rx_pack
  import hdlc_rx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int HOLD = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dvld_i,
  input  logic          dbit_i,
  input  logic          eof_i,
  input  logic          abort_i,
  input  logic          crc_ok_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output tag_e          wr_tag_o
);
  localparam int MIN_BITS = HOLD * DW + 1;
  localparam int LW       = $clog2(MIN_BITS + 1);
  localparam int PW       = $clog2(DW);

  logic [DW-1:0] sr_q, byte_d;
  logic [DW-1:0] hold_q [HOLD];
  logic [LW-1:0] len_q;
  logic [PW-1:0] ph_q;
  logic          started_q, push, mid_wr, end_wr, whole;

  assign byte_d = {dbit_i, sr_q[DW-1:1]};
  assign push   = dvld_i && (ph_q == PW'(DW - 1));
  assign mid_wr = dvld_i && (ph_q == '0) && (len_q >= LW'(MIN_BITS - 1));
  assign end_wr = eof_i && (len_q >= LW'(MIN_BITS));
  assign whole  = (ph_q == '0);

  for (genvar g = 0; g < HOLD; g++) begin : g_hold
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hold_q[g] <= '0;
        else if (push) hold_q[g] <= byte_d;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hold_q[g] <= '0;
        else if (push) hold_q[g] <= hold_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      len_q     <= '0;
      ph_q      <= '0;
      started_q <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      wr_tag_o  <= TAG_MID;
    end else begin
      wr_en_o <= 1'b0;
      if (eof_i) begin
        len_q     <= '0;
        ph_q      <= '0;
        started_q <= 1'b0;
        if (end_wr) begin
          wr_en_o   <= 1'b1;
          // partial last byte: the oldest unwritten byte sits one stage earlier
          wr_data_o <= whole ? hold_q[HOLD-1] : hold_q[HOLD-2];
          wr_tag_o  <= (whole && crc_ok_i && !abort_i) ? TAG_END_OK : TAG_END_BAD;
        end
      end else if (dvld_i) begin
        sr_q <= byte_d;
        ph_q <= ph_q + PW'(1);
        if (len_q != LW'(MIN_BITS)) len_q <= len_q + LW'(1);
        if (mid_wr) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= hold_q[HOLD-1];
          wr_tag_o  <= started_q ? TAG_MID : TAG_FIRST;
          started_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_ONES = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [1:0]        wr_tag_o,
  output logic              idle_o,
  output logic              go_ahead_o
);
  logic dvld, dbit, eof, eof_abort, crc_ok;
  tag_e tag;

  hdlc_rx_line #(.IDLE_ONES(IDLE_ONES)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .bit_i      (bit_i),
    .dvld_o     (dvld),
    .dbit_o     (dbit),
    .eof_o      (eof),
    .eof_abort_o(eof_abort),
    .idle_o     (idle_o),
    .go_ahead_o (go_ahead_o)
  );

  hdlc_rx_crc u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (eof),
    .en_i  (dvld),
    .bit_i (dbit),
    .ok_o  (crc_ok)
  );

  hdlc_rx_pack #(.DW(DATA_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dvld_i   (dvld),
    .dbit_i   (dbit),
    .eof_i    (eof),
    .abort_i  (eof_abort),
    .crc_ok_i (crc_ok),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o),
    .wr_tag_o (tag)
  );

  assign wr_tag_o = tag;
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk
  import hdlc_rx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       bit_i,
  input logic       wr_en_o,
  input logic [1:0] wr_tag_o,
  input logic       idle_o,
  input logic       go_ahead_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               open_q <= 1'b0;
    else if (wr_en_o && wr_tag_o == TAG_FIRST) open_q <= 1'b1;
    else if (wr_en_o && wr_tag_o[1])           open_q <= 1'b0;
  end

  AST_FIRST_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tag_o == TAG_FIRST) |-> !open_q); // R8
  AST_CONT_IN_PACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tag_o != TAG_FIRST) |-> open_q); // R8
  AST_MID_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_tag_o[1]) |-> $past(bit_en_i)); // R12
  AST_END_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_tag_o[1]) |-> $past(bit_en_i, 2)); // R7
  AST_IDLE_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(bit_en_i && bit_i)); // R9
  AST_GA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_ahead_o |=> !go_ahead_o); // R10
  AST_GA_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_ahead_o) |-> $past(bit_en_i && !bit_i)); // R10
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_en_i  (bit_en_i),
  .bit_i     (bit_i),
  .wr_en_o   (wr_en_o),
  .wr_tag_o  (wr_tag_o),
  .idle_o    (idle_o),
  .go_ahead_o(go_ahead_o)
);

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       wr_en_o, idle_o, go_ahead_o;
  logic [7:0] wr_data_o;
  logic [1:0] wr_tag_o;

  int checks = 0;
  int fails  = 0;
  int gap    = 0;
  int tx_ones = 0;
  bit done   = 1'b0;

  logic [9:0]  exp_q [$];
  string       req_q [$];
  logic [7:0]  frm   [$];

  always #4 clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bit_en_i  (bit_en),
    .bit_i     (bit_in),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .wr_tag_o  (wr_tag_o),
    .idle_o    (idle_o),
    .go_ahead_o(go_ahead_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [1:0] tag, input logic [7:0] data, input string req);
    exp_q.push_back({tag, data});
    req_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 R8 unexpected write", int'({wr_tag_o, wr_data_o}), 0);
      end else begin
        logic [9:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({wr_tag_o, wr_data_o} == e, r, int'({wr_tag_o, wr_data_o}), int'(e));
      end
    end
  end

  task automatic drv_bit(input logic b);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_flag();
    drv_bit(1'b0);
    repeat (6) drv_bit(1'b1);
    drv_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_dbit(input logic b);
    drv_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin
        drv_bit(1'b0);
        tx_ones = 0;
      end
    end else begin
      tx_ones = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] x);
    for (int i = 0; i < 8; i++) send_dbit(x[i]);
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] x);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ x[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  // sends frm with FCS and a closing flag, queues expected writes
  task automatic send_frame(input bit corrupt, input string req);
    logic [15:0] c;
    int n;
    n = frm.size();
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = crc_byte(c, frm[i]);
      if (i == 0)          expect_wr(2'b01, frm[i], req);
      else if (i == n - 1) expect_wr(corrupt ? 2'b11 : 2'b10, frm[i], req);
      else                 expect_wr(2'b00, frm[i], req);
    end
    c = ~c;
    if (corrupt) c[3] = ~c[3];
    for (int i = 0; i < n; i++) send_byte(frm[i]);
    send_byte(c[7:0]);
    send_byte(c[15:8]);
    send_flag();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(wr_en_o == 1'b0, "R11 wr_en in reset", int'(wr_en_o), 0);
    chk(idle_o == 1'b0, "R11 idle in reset", int'(idle_o), 0);
    chk(go_ahead_o == 1'b0, "R11 go_ahead in reset", int'(go_ahead_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    repeat (3) drv_bit(1'b1);
    send_flag();

    // R1 R2 R5: good frame with stuffing-heavy payload
    frm = '{8'h12, 8'hFF, 8'h7E, 8'h34};
    send_frame(1'b0, "R1 R2 R5 good frame");

    // R12: same path with blank cycles between bits
    gap = 2;
    frm = '{8'hA5, 8'h0F};
    send_frame(1'b0, "R12 gapped good frame");
    gap = 0;

    // R3: 24 bits between flags, nothing written
    send_byte(8'h11);
    send_byte(8'h22);
    send_byte(8'h33);
    send_flag();

    // R4: 27 bits -> first byte then last-bad
    expect_wr(2'b01, 8'h01, "R4 first of 27-bit frame");
    expect_wr(2'b11, 8'h02, "R4 bad end of 27-bit frame");
    send_byte(8'h01);
    send_byte(8'h02);
    send_byte(8'h03);
    repeat (3) send_dbit(1'b0);
    send_flag();

    // R6: wrong FCS
    frm = '{8'h5A, 8'hC3, 8'h99};
    send_frame(1'b1, "R6 bad FCS");

    // R7: abort after 39 recovered bits
    expect_wr(2'b01, 8'h10, "R7 abort first");
    expect_wr(2'b00, 8'h20, "R7 abort mid");
    expect_wr(2'b11, 8'h30, "R7 abort bad end");
    send_byte(8'h10);
    send_byte(8'h20);
    send_byte(8'h30);
    send_byte(8'h40);
    send_byte(8'h00);
    repeat (8) drv_bit(1'b1);

    // R7: short frame aborted, then run into idle (R9)
    send_flag();
    send_byte(8'h01);
    send_byte(8'h02);
    for (int i = 1; i <= 16; i++) begin
      drv_bit(1'b1);
      if (i == 14) chk(idle_o == 1'b0, "R9 idle after 14 ones", int'(idle_o), 0);
      if (i == 15) chk(idle_o == 1'b1, "R9 idle after 15 ones", int'(idle_o), 1);
    end
    drv_bit(1'b0);
    chk(idle_o == 1'b0, "R9 idle cleared by zero", int'(idle_o), 0);

    // R10: go-ahead
    repeat (7) drv_bit(1'b1);
    chk(go_ahead_o == 1'b0, "R10 no go-ahead before closing zero", int'(go_ahead_o), 0);
    drv_bit(1'b0);
    chk(go_ahead_o == 1'b1, "R10 go-ahead pulse", int'(go_ahead_o), 1);
    @(negedge clk);
    chk(go_ahead_o == 1'b0, "R10 go-ahead one cycle", int'(go_ahead_o), 0);

    // R1: recovery after abort and idle
    send_flag();
    frm = '{8'hC0, 8'hDE, 8'h00};
    send_frame(1'b0, "R1 R8 frame after idle");

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R3 R8 all expected writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule